// File: doc/BRIEF.md
# Touchscreen Digitizer Serial Port Controller

This block is the digital half of a resistive touchscreen digitizer's serial slave port. A host lowers chip select and clocks a 24-cycle transaction. The first eight serial clocks carry a control word: a start bit, a three-bit channel code, a resolution select, a reference select and a two-bit power-down code. The following clocks return the converted sample most significant bit first, with zero fill after it. The converted value comes in as a parallel word on `sample_in`. The block captures that word at the hold instant, which is the rising serial clock that delivers the last control bit. At that same instant it raises a one-shot BUSY indication.

The block also sequences the panel switches. It turns the X or Y driver pair on during acquisition when the channel calls for it. It releases the pair at hold or at the end of conversion, depending on the reference and power-down settings. It turns the Y-minus pen-detect switch on when the converter powers down between conversions.

All activity runs on one system clock `clk`. The serial clock, chip select and data input are sampled signals, and the serial clock must stay at each level for at least two `clk` cycles. Instead of real tristate pins, the block provides output-enable signals that are registered from chip select.

Top module: `tsc_serial_if`

## Requirements
- R1: `sdo_oe` and `busy_oe` equal the inverse of `cs_n` as sampled one `clk` cycle earlier. While `cs_n` is high, `sdo` and `busy` are held at 0.
- R2: While no transaction is open, a rising serial clock with `sdi` = 0 is ignored. It changes no configuration output and raises no BUSY. A rising edge with `sdi` = 1 opens a transaction.
- R3: The seven bits that follow the start bit are taken as A2, A1, A0, MODE, REF, PD1, PD0, in that order. They reach `cfg_chan`, `cfg_mode`, `cfg_ser` and `cfg_pd` together on the 8th rising edge, and the configuration changes at no other time.
- R4: `busy` rises after the 8th rising edge and falls after the next falling serial clock edge.
- R5: `sample_in` is captured at the 8th rising edge. With MODE = 0, the falling edges that follow present result bits 11 down to 0, one per edge. The host reads each bit on rising edges 9 to 20.
- R6: After the result, `sdo` is 0 up to the 24th rising edge. After that edge the port again waits for a start bit without chip select rising.
- R7: With MODE = 1, only result bits 11 down to 4 are presented (rising edges 9 to 16), followed by zeros.
- R8: At the 4th rising edge, channel code 001 turns `y_drv_en` on and code 101 turns `x_drv_en` on. Any other code leaves both off. At most one of the two is on at any time, and `ym_drv_en` turns off.
- R9: With REF = 1 (single-ended), both driver enables turn off at the 8th rising edge.
- R10: With REF = 0 (ratiometric), the drivers stay on through the conversion. At the 20th rising edge, a power-down code other than 11 turns them off and turns `ym_drv_en` on. `ym_drv_en` is never on together with a driver enable.
- R11: With power-down code 11, the drivers remain on after the transaction until `cs_n` rises or the next acquisition reloads them.
- R12: If `cs_n` rises mid-transaction, the bit count clears, both driver enables and `busy` drop, and the configuration keeps the last complete control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| sdi | input | 1 | Serial data in, sampled on the serial clock's rising edge |
| sample_in | input | 12 | Converted sample, captured at hold |
| sdo | output | 1 | Serial data out, updated on the serial clock's falling edge |
| sdo_oe | output | 1 | Drive enable for `sdo` |
| busy | output | 1 | Conversion-start indication |
| busy_oe | output | 1 | Drive enable for `busy` |
| x_drv_en | output | 1 | X panel driver switch enable |
| y_drv_en | output | 1 | Y panel driver switch enable |
| ym_drv_en | output | 1 | Y-minus pen-detect switch enable |
| cfg_chan | output | 3 | Committed channel code |
| cfg_mode | output | 1 | Committed resolution select (1 = 8-bit) |
| cfg_ser | output | 1 | Committed reference select (1 = single-ended) |
| cfg_pd | output | 2 | Committed power-down code |

## Verification
The hardest states to reach from the ports are the abandoned transaction and the kept-on drivers. Both need a specific history of earlier transactions: a complete word with power-down code 11 left in the configuration, then a new word cut off after the acquisition edge but before hold. The stimulus reaches these states with a resumable transaction task that can stop at any serial clock index. The bench raises chip select at that point, checks that the drivers fall while the configuration keeps the older word, and then runs a full transaction to show that the port recovers. A second transaction is also started directly after the first with no chip select pulse, to exercise the return-to-idle path.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int CHAN_W = 3;
  localparam logic [CHAN_W-1:0] CH_DRIVE_Y = 3'b001;
  localparam logic [CHAN_W-1:0] CH_DRIVE_X = 3'b101;
  localparam logic [1:0] PD_STAY_ON = 2'b11;

  typedef struct packed {
    logic [CHAN_W-1:0] chan;
    logic              mode;
    logic              ser;
    logic [1:0]        pd;
  } tsc_cfg_t;
endpackage

// File: rtl/tsc_ctrl_rx.sv
module tsc_ctrl_rx
  import tsc_pkg::*;
#(
  parameter int FRAME_CLKS = 24,
  parameter int CTRL_W     = 8,
  parameter int RES_W      = 12,
  parameter int CNT_W      = $clog2(FRAME_CLKS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sdi,
  input  logic              rise,
  output logic [CNT_W-1:0]  cnt,
  output logic              acq_evt,
  output logic [CHAN_W-1:0] acq_chan,
  output logic              hold_evt,
  output tsc_cfg_t          hold_cfg,
  output logic              eoc_evt,
  output tsc_cfg_t          cfg
);
  localparam int CFG_W  = $bits(tsc_cfg_t);
  localparam int ACQ_AT = 1 + CHAN_W;
  localparam int EOC_AT = CTRL_W + RES_W;

  logic [CFG_W-1:0] work;
  logic [CFG_W-1:0] next_word;
  logic             active_rise;

  assign next_word   = {work[CFG_W-2:0], sdi};
  assign active_rise = rise && !cs_n;
  assign acq_chan    = next_word[CHAN_W-1:0];
  assign hold_cfg    = tsc_cfg_t'(next_word);
  assign acq_evt     = active_rise && (cnt == CNT_W'(ACQ_AT - 1));
  assign hold_evt    = active_rise && (cnt == CNT_W'(CTRL_W - 1));
  assign eoc_evt     = active_rise && (cnt == CNT_W'(EOC_AT - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      work <= '0;
      cfg  <= '0;
    end else if (cs_n) begin
      cnt <= '0;
    end else if (rise) begin
      if (cnt == '0) begin
        if (sdi) cnt <= CNT_W'(1);
      end else begin
        work <= next_word;
        if (cnt == CNT_W'(FRAME_CLKS - 1)) cnt <= '0;
        else                              cnt <= cnt + 1'b1;
        if (hold_evt) cfg <= hold_cfg;
      end
    end
  end
endmodule

// File: rtl/tsc_result_tx.sv
module tsc_result_tx #(
  parameter int RES_W   = 12,
  parameter int SHORT_W = 8,
  parameter int CTRL_W  = 8,
  parameter int CNT_W   = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             fall,
  input  logic             hold_evt,
  input  logic [CNT_W-1:0] cnt,
  input  logic             short_mode,
  input  logic [RES_W-1:0] sample,
  output logic             sdo,
  output logic             busy
);
  localparam int IDX_W = $clog2(RES_W + 1) + 1;

  logic [RES_W-1:0] held;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] len;
  logic             in_data;
  logic             bit_val;

  assign len     = short_mode ? IDX_W'(SHORT_W) : IDX_W'(RES_W);
  assign idx     = IDX_W'(cnt) - IDX_W'(CTRL_W);
  assign in_data = (cnt >= CNT_W'(CTRL_W)) && (idx < len);

  always_comb begin
    bit_val = 1'b0;
    for (int i = 0; i < RES_W; i++) begin
      if (in_data && (idx == IDX_W'(RES_W - 1 - i))) bit_val = held[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      held <= '0;
      sdo  <= 1'b0;
      busy <= 1'b0;
    end else if (cs_n) begin
      sdo  <= 1'b0;
      busy <= 1'b0;
    end else begin
      if (hold_evt) begin
        held <= sample;
        busy <= 1'b1;
      end
      if (fall) begin
        busy <= 1'b0;
        sdo  <= bit_val;
      end
    end
  end
endmodule

// File: rtl/tsc_panel_drv.sv
module tsc_panel_drv
  import tsc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              acq_evt,
  input  logic [CHAN_W-1:0] acq_chan,
  input  logic              hold_evt,
  input  logic              hold_ser,
  input  logic              eoc_evt,
  input  logic [1:0]        pd,
  output logic              x_en,
  output logic              y_en,
  output logic              ym_en
);
  always_ff @(posedge clk) begin
    if (rst) begin
      x_en  <= 1'b0;
      y_en  <= 1'b0;
      ym_en <= 1'b0;
    end else if (cs_n) begin
      x_en <= 1'b0;
      y_en <= 1'b0;
    end else if (acq_evt) begin
      x_en  <= (acq_chan == CH_DRIVE_X);
      y_en  <= (acq_chan == CH_DRIVE_Y);
      ym_en <= 1'b0;
    end else if (hold_evt && hold_ser) begin
      x_en <= 1'b0;
      y_en <= 1'b0;
    end else if (eoc_evt && (pd != PD_STAY_ON)) begin
      x_en  <= 1'b0;
      y_en  <= 1'b0;
      ym_en <= 1'b1;
    end
  end
endmodule

// File: rtl/tsc_serial_if.sv
module tsc_serial_if
  import tsc_pkg::*;
#(
  parameter int RES_W      = 12,
  parameter int SHORT_W    = 8,
  parameter int CTRL_W     = 8,
  parameter int FRAME_CLKS = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sclk,
  input  logic             cs_n,
  input  logic             sdi,
  input  logic [RES_W-1:0] sample_in,
  output logic             sdo,
  output logic             sdo_oe,
  output logic             busy,
  output logic             busy_oe,
  output logic             x_drv_en,
  output logic             y_drv_en,
  output logic             ym_drv_en,
  output logic [2:0]       cfg_chan,
  output logic             cfg_mode,
  output logic             cfg_ser,
  output logic [1:0]       cfg_pd
);
  localparam int CNT_W = $clog2(FRAME_CLKS + 1);

  logic              sclk_q;
  logic              rise;
  logic              fall;
  logic [CNT_W-1:0]  cnt;
  logic              acq_evt;
  logic              hold_evt;
  logic              eoc_evt;
  logic [CHAN_W-1:0] acq_chan;
  tsc_cfg_t          hold_cfg;
  tsc_cfg_t          cfg;

  assign rise = sclk && !sclk_q;
  assign fall = !sclk && sclk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q  <= 1'b0;
      sdo_oe  <= 1'b0;
      busy_oe <= 1'b0;
    end else begin
      sclk_q  <= sclk;
      sdo_oe  <= !cs_n;
      busy_oe <= !cs_n;
    end
  end

  tsc_ctrl_rx #(
    .FRAME_CLKS(FRAME_CLKS), .CTRL_W(CTRL_W), .RES_W(RES_W), .CNT_W(CNT_W)
  ) rx_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sdi(sdi), .rise(rise), .cnt(cnt),
    .acq_evt(acq_evt), .acq_chan(acq_chan), .hold_evt(hold_evt),
    .hold_cfg(hold_cfg), .eoc_evt(eoc_evt), .cfg(cfg)
  );

  tsc_result_tx #(
    .RES_W(RES_W), .SHORT_W(SHORT_W), .CTRL_W(CTRL_W), .CNT_W(CNT_W)
  ) tx_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .fall(fall), .hold_evt(hold_evt),
    .cnt(cnt), .short_mode(cfg.mode), .sample(sample_in), .sdo(sdo),
    .busy(busy)
  );

  tsc_panel_drv drv_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .acq_evt(acq_evt),
    .acq_chan(acq_chan), .hold_evt(hold_evt), .hold_ser(hold_cfg.ser),
    .eoc_evt(eoc_evt), .pd(cfg.pd), .x_en(x_drv_en), .y_en(y_drv_en),
    .ym_en(ym_drv_en)
  );

  assign cfg_chan = cfg.chan;
  assign cfg_mode = cfg.mode;
  assign cfg_ser  = cfg.ser;
  assign cfg_pd   = cfg.pd;
endmodule

// File: rtl/tsc_serial_if_chk.sv
module tsc_serial_if_chk (
  input logic       clk,
  input logic       rst,
  input logic       sclk,
  input logic       cs_n,
  input logic       busy,
  input logic       x_drv_en,
  input logic       y_drv_en,
  input logic       ym_drv_en,
  input logic [2:0] cfg_chan,
  input logic [1:0] cfg_pd
);
  assert_cfg_only_at_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!$stable(cfg_chan) || !$stable(cfg_pd)) |-> busy);

  assert_busy_ends_on_fall_R4: assert property (@(posedge clk) disable iff (rst)
    (busy && !sclk && $past(sclk)) |=> !busy);

  assert_one_driver_pair_R8: assert property (@(posedge clk) disable iff (rst)
    !(x_drv_en && y_drv_en));

  assert_pen_detect_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
    !(ym_drv_en && (x_drv_en || y_drv_en)));

  assert_abort_drops_drivers_R12: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> (!x_drv_en && !y_drv_en && !busy));
endmodule

bind tsc_serial_if tsc_serial_if_chk chk_i (
  .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .busy(busy),
  .x_drv_en(x_drv_en), .y_drv_en(y_drv_en), .ym_drv_en(ym_drv_en),
  .cfg_chan(cfg_chan), .cfg_pd(cfg_pd)
);

// File: tb/tsc_serial_if_tb_top.sv
`timescale 1ns/1ps
module tsc_serial_if_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sclk = 1'b0;
  logic        cs_n = 1'b1;
  logic        sdi = 1'b0;
  logic [11:0] sample_in = '0;
  logic        sdo, sdo_oe, busy, busy_oe, x_drv_en, y_drv_en, ym_drv_en;
  logic [2:0]  cfg_chan;
  logic        cfg_mode, cfg_ser;
  logic [1:0]  cfg_pd;

  always #2.5 clk = ~clk;

  tsc_serial_if dut_i (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
    .sample_in(sample_in), .sdo(sdo), .sdo_oe(sdo_oe), .busy(busy),
    .busy_oe(busy_oe), .x_drv_en(x_drv_en), .y_drv_en(y_drv_en),
    .ym_drv_en(ym_drv_en), .cfg_chan(cfg_chan), .cfg_mode(cfg_mode),
    .cfg_ser(cfg_ser), .cfg_pd(cfg_pd)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;
  bit cap [0:23];
  bit word [0:7];

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // Behavioural reference model, advanced on every clock
  bit   m_valid = 0, m_prev = 0;
  int   m_n = 0, m_chan = 0, m_mode = 0, m_ser = 0, m_pd = 0;
  bit   q[$];
  logic [11:0] m_res = '0;
  bit   m_busy = 0, m_sdo = 0, m_x = 0, m_y = 0, m_ym = 0, m_oe = 0;

  always @(posedge clk) begin
    bit r, f;
    if (rst) begin
      m_valid = 0; m_prev = 0; m_n = 0; m_chan = 0; m_mode = 0; m_ser = 0;
      m_pd = 0; m_res = '0; m_busy = 0; m_sdo = 0; m_x = 0; m_y = 0;
      m_ym = 0; m_oe = 0;
    end else begin
      m_valid = 1;
      m_oe = !cs_n;
      r = sclk && !m_prev;
      f = !sclk && m_prev;
      m_prev = sclk;
      if (cs_n) begin
        m_n = 0; m_busy = 0; m_sdo = 0; m_x = 0; m_y = 0;
      end else if (r) begin
        if (m_n == 0) begin
          if (sdi) begin m_n = 1; q.delete(); end
        end else begin
          m_n++;
          q.push_back(sdi);
          if (m_n == 4) begin
            int c;
            c = q[0]*4 + q[1]*2 + q[2];
            m_y = (c == 1); m_x = (c == 5); m_ym = 0;
          end
          if (m_n == 8) begin
            m_chan = q[0]*4 + q[1]*2 + q[2];
            m_mode = q[3]; m_ser = q[4]; m_pd = q[5]*2 + q[6];
            m_res = sample_in; m_busy = 1;
            if (m_ser) begin m_x = 0; m_y = 0; end
          end
          if (m_n == 20 && m_pd != 3) begin m_x = 0; m_y = 0; m_ym = 1; end
          if (m_n == 24) m_n = 0;
        end
      end else if (f) begin
        int k, w;
        m_busy = 0;
        k = m_n - 8;
        w = m_mode ? 8 : 12;
        m_sdo = (m_n >= 8 && k < w) ? m_res[11-k] : 1'b0;
      end
    end
  end

  always @(negedge clk) begin
    if (m_valid && !done) begin
      chk("R1 sdo_oe", sdo_oe, m_oe);
      chk("R1 busy_oe", busy_oe, m_oe);
      chk("R3 cfg_chan", cfg_chan, m_chan);
      chk("R3 cfg_mode", cfg_mode, m_mode);
      chk("R3 cfg_ser", cfg_ser, m_ser);
      chk("R3 cfg_pd", cfg_pd, m_pd);
      chk("R4 busy", busy, m_busy);
      chk("R5 sdo", sdo, m_sdo);
      chk("R8 x_drv_en", x_drv_en, m_x);
      chk("R8 y_drv_en", y_drv_en, m_y);
      chk("R10 ym_drv_en", ym_drv_en, m_ym);
    end
  end

  task automatic tick(input bit d, input int i);
    @(negedge clk); sdi = d;
    @(negedge clk); cap[i] = sdo; sclk = 1'b1;
    @(negedge clk);
    @(negedge clk); sclk = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_word(input int chan, input int mode, input int ser, input int pd);
    word[0] = 1; word[1] = chan[2]; word[2] = chan[1]; word[3] = chan[0];
    word[4] = mode[0]; word[5] = ser[0]; word[6] = pd[1]; word[7] = pd[0];
  endtask

  task automatic run_ticks(input int from, input int to);
    for (int i = from; i <= to; i++) tick((i < 8) ? word[i] : 1'b0, i);
  endtask

  task automatic open_cs();
    @(negedge clk); cs_n = 1'b0;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic close_cs();
    @(negedge clk); cs_n = 1'b1;
    @(negedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      finish_up();
    end
  end

  initial begin
    logic [11:0] s;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset sdo_oe", sdo_oe, 0);
    chk("R3 reset cfg_chan", cfg_chan, 0);
    chk("R8 reset x_drv_en", x_drv_en, 0);

    // R2: idle rising edges with sdi low are ignored
    open_cs();
    chk("R1 sdo_oe after cs low", sdo_oe, 1);
    chk("R1 busy_oe after cs low", busy_oe, 1);
    for (int i = 0; i < 3; i++) tick(1'b0, 0);
    chk("R2 busy after idle clocks", busy, 0);
    chk("R2 cfg_chan after idle clocks", cfg_chan, 0);

    // Ratiometric Y read, pd 00, 12-bit
    s = 12'hA5C; sample_in = s;
    set_word(1, 0, 0, 0);
    run_ticks(0, 23);
    chk("R3 cfg_chan", cfg_chan, 1);
    chk("R3 cfg_pd", cfg_pd, 0);
    for (int k = 0; k < 12; k++) chk("R5 result bit", cap[8+k], s[11-k]);
    for (int k = 20; k < 24; k++) chk("R6 zero fill", cap[k], 0);
    chk("R10 y_drv_en off at eoc", y_drv_en, 0);
    chk("R10 ym_drv_en on at eoc", ym_drv_en, 1);

    // Back-to-back: single-ended X read, 8-bit, pd 11
    s = 12'h3C9; sample_in = s;
    set_word(5, 1, 1, 3);
    run_ticks(0, 5);
    chk("R8 x_drv_en during acquisition", x_drv_en, 1);
    chk("R8 ym_drv_en off during acquisition", ym_drv_en, 0);
    run_ticks(6, 23);
    chk("R9 x_drv_en off after hold", x_drv_en, 0);
    chk("R7 cfg_mode", cfg_mode, 1);
    for (int k = 0; k < 8; k++) chk("R7 short result bit", cap[8+k], s[11-k]);
    for (int k = 16; k < 24; k++) chk("R7 short zero fill", cap[k], 0);
    chk("R11 ym_drv_en stays off", ym_drv_en, 0);

    // R11: ratiometric Y with pd 11 keeps drivers on after frame
    s = 12'h5F0; sample_in = s;
    set_word(1, 0, 0, 3);
    run_ticks(0, 23);
    chk("R11 y_drv_en held after frame", y_drv_en, 1);
    repeat (6) @(negedge clk);
    chk("R11 y_drv_en still held", y_drv_en, 1);
    close_cs();
    chk("R11 y_drv_en off after cs high", y_drv_en, 0);
    chk("R1 sdo_oe off after cs high", sdo_oe, 0);

    // R12: abort after acquisition, before hold
    open_cs();
    set_word(5, 0, 0, 0);
    run_ticks(0, 4);
    chk("R12 x_drv_en before abort", x_drv_en, 1);
    close_cs();
    chk("R12 x_drv_en after abort", x_drv_en, 0);
    chk("R12 cfg_chan kept", cfg_chan, 1);
    chk("R12 cfg_pd kept", cfg_pd, 3);
    chk("R12 busy after abort", busy, 0);

    // Recovery with a non-driving channel
    open_cs();
    s = 12'h801; sample_in = s;
    set_word(3, 0, 0, 1);
    run_ticks(0, 5);
    chk("R8 no driver for code 011 x", x_drv_en, 0);
    chk("R8 no driver for code 011 y", y_drv_en, 0);
    run_ticks(6, 23);
    chk("R12 cfg_chan after recovery", cfg_chan, 3);
    for (int k = 0; k < 12; k++) chk("R5 recovery bit", cap[8+k], s[11-k]);
    chk("R6 idle after frame busy", busy, 0);
    close_cs();
    finish_up();
  end
endmodule